// File: doc/BRIEF.md
# Priority-Multiplexed GPIO Port

This block is an eight-pin (parameterisable) general-purpose I/O port with pin interrupts. Software reaches it through a simple register bus. The bus gives access to an output data register and a direction register. It also gives access to a read-only view of the pin levels, a per-pin edge-polarity selector, an interrupt enable register and write-one-to-clear interrupt flags. Before any use, the pin levels pass through a two-stage synchroniser.

Each pin can be taken over by an alternate peripheral output. A PWM output has the highest priority. A timer output comes next. A serial output is available only on the pins named by a parameter mask. A pin with none of these enabled falls back to the GPIO registers. An alternate owner always enables the pad driver. The block produces per-pin drive values and output enables, plus one combined interrupt line.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset, the data, direction, interrupt-enable, edge-select and flag registers are all 0. Every pad output enable is 0 and `irq` is 0.
- R2: A pin with no enabled alternate function has `pad_out` equal to its data bit and `pad_oe` equal to its direction bit (1 = output).
- R3: An enabled PWM channel drives its pin with `pwm_val` and `pad_oe`=1, overriding timer, serial and GPIO. An enabled timer channel with PWM off drives `tmr_val` with `pad_oe`=1, overriding serial and GPIO.
- R4: The serial output (`ser_val`, `pad_oe`=1) takes a pin only where bit i of `SER_MASK` is 1 (default 8'hC0, pins 6 and 7) and PWM and timer are off. On any other pin, `ser_en` has no effect.
- R5: A read at address 0 (data) returns, for each bit, the stored data bit when its direction bit is 1 and the synchronised pin level when it is 0. Address 1 is direction, address 3 is interrupt enable and address 4 is edge select (1 = rising, 0 = falling). All three are read/write.
- R6: A read at address 2 (input) returns the synchronised pin level whatever the direction. A pin change is visible there within 2 clock edges.
- R7: Writes to address 2, and to unused addresses 6 and 7, change no register. Unused addresses read 0.
- R8: An edge of the selected polarity on a synchronised pin sets that pin's flag (address 5) only if its enable bit is 1, in input or output mode alike. The flag is set 3 clock edges after the pin change.
- R9: Writing 1 to a flag bit at address 5 clears it and writing 0 leaves it. An edge arriving in the same cycle as the clear wins, so the flag stays set.
- R10: `irq` is 1 exactly when some flag bit and its enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | N_PINS | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | N_PINS | Read data for `bus_addr` (combinational) |
| pin_in | input | N_PINS | Asynchronous pin levels |
| pwm_en | input | N_PINS | PWM channel enables |
| pwm_val | input | N_PINS | PWM output levels |
| tmr_en | input | N_PINS | Timer output enables |
| tmr_val | input | N_PINS | Timer output levels |
| ser_en | input | N_PINS | Serial output enables |
| ser_val | input | N_PINS | Serial output levels |
| pad_out | output | N_PINS | Pad drive values |
| pad_oe | output | N_PINS | Pad output enables |
| irq | output | 1 | Combined pin interrupt |

## Verification
The bench sets PWM, timer and serial enables at random all at once. A priority inversion therefore shows up as the wrong pad value, and a serial enable that leaks onto an unmasked pin shows up as a wrong output enable. It reads the data register with mixed direction bits and the pin input different from the stored data, so a read mux that ignores the direction returns the wrong half. It fires edges on pins whose enable is off, which a design that flags unconditionally would record. It also aims a flag clear at the exact cycle an edge lands, which a design giving the clear priority would lose. Writes to the input address and to unused addresses must leave every register as it was.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
   localparam int unsigned REG_AW     = 3;
   localparam logic [REG_AW-1:0] ADR_DATA  = 3'd0;
   localparam logic [REG_AW-1:0] ADR_DIR   = 3'd1;
   localparam logic [REG_AW-1:0] ADR_INPUT = 3'd2;
   localparam logic [REG_AW-1:0] ADR_IEN   = 3'd3;
   localparam logic [REG_AW-1:0] ADR_EDGE  = 3'd4;
   localparam logic [REG_AW-1:0] ADR_FLAG  = 3'd5;

   typedef enum logic [1:0] {
      OWN_GPIO  = 2'd0,
      OWN_SER   = 2'd1,
      OWN_TMR   = 2'd2,
      OWN_PWM   = 2'd3
   } pin_owner_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);
   logic [WIDTH-1:0] stage_q [STAGES];

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   // Pin levels carry no reset on purpose: they only mirror the pads.
   always_ff @(posedge clk) begin
      stage_q[0] <= async_in;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         stage_q[s] <= stage_q[s-1];
      end
   end

   assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
   import gpio_mux_pkg::*;
#(
   parameter int unsigned      WIDTH    = 8,
   parameter logic [WIDTH-1:0] SER_MASK = '0
) (
   input  logic [WIDTH-1:0] gpio_data,
   input  logic [WIDTH-1:0] gpio_dir,
   input  logic [WIDTH-1:0] pwm_en,
   input  logic [WIDTH-1:0] pwm_val,
   input  logic [WIDTH-1:0] tmr_en,
   input  logic [WIDTH-1:0] tmr_val,
   input  logic [WIDTH-1:0] ser_en,
   input  logic [WIDTH-1:0] ser_val,
   output logic [WIDTH-1:0] pad_out,
   output logic [WIDTH-1:0] pad_oe
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      pin_owner_e owner;

      if (SER_MASK[i]) begin : g_with_ser
         always_comb begin
            if (pwm_en[i])       owner = OWN_PWM;
            else if (tmr_en[i])  owner = OWN_TMR;
            else if (ser_en[i])  owner = OWN_SER;
            else                 owner = OWN_GPIO;
         end
      end else begin : g_no_ser
         always_comb begin
            if (pwm_en[i])       owner = OWN_PWM;
            else if (tmr_en[i])  owner = OWN_TMR;
            else                 owner = OWN_GPIO;
         end
      end

      always_comb begin
         unique case (owner)
            OWN_PWM: begin pad_out[i] = pwm_val[i]; pad_oe[i] = 1'b1; end
            OWN_TMR: begin pad_out[i] = tmr_val[i]; pad_oe[i] = 1'b1; end
            OWN_SER: begin pad_out[i] = ser_val[i]; pad_oe[i] = 1'b1; end
            default: begin pad_out[i] = gpio_data[i]; pad_oe[i] = gpio_dir[i]; end
         endcase
      end
   end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pin_sync,
   input  logic [WIDTH-1:0] rise_sel,
   input  logic [WIDTH-1:0] enable,
   input  logic [WIDTH-1:0] clr_mask,
   output logic [WIDTH-1:0] flags,
   output logic             irq
);
   logic [WIDTH-1:0] prev_q;
   logic [WIDTH-1:0] hit;
   logic [WIDTH-1:0] flag_q;

   always_ff @(posedge clk) begin
      prev_q <= pin_sync;
   end

   assign hit = ((pin_sync & ~prev_q & rise_sel) |
                 (~pin_sync & prev_q & ~rise_sel)) & enable;

   // A new edge wins over a clear landing in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= (flag_q & ~clr_mask) | hit;
   end

   assign flags = flag_q;
   assign irq   = |(flag_q & enable);
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
   import gpio_mux_pkg::*;
#(
   parameter int unsigned       N_PINS      = 8,
   parameter int unsigned       ADDR_W      = 3,
   parameter int unsigned       SYNC_STAGES = 2,
   parameter logic [N_PINS-1:0] SER_MASK    = 8'hC0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [N_PINS-1:0] bus_wdata,
   input  logic              bus_we,
   output logic [N_PINS-1:0] bus_rdata,
   input  logic [N_PINS-1:0] pin_in,
   input  logic [N_PINS-1:0] pwm_en,
   input  logic [N_PINS-1:0] pwm_val,
   input  logic [N_PINS-1:0] tmr_en,
   input  logic [N_PINS-1:0] tmr_val,
   input  logic [N_PINS-1:0] ser_en,
   input  logic [N_PINS-1:0] ser_val,
   output logic [N_PINS-1:0] pad_out,
   output logic [N_PINS-1:0] pad_oe,
   output logic              irq
);
   localparam int unsigned HI_W = (ADDR_W > REG_AW) ? ADDR_W - REG_AW : 1;

   if (N_PINS < 1 || N_PINS > 32) begin : g_bad_pins
      $error("gpio_mux_port: N_PINS must be 1..32");
   end
   if (ADDR_W < REG_AW) begin : g_bad_addr
      $error("gpio_mux_port: ADDR_W too small for register map");
   end

   logic [REG_AW-1:0] reg_sel;
   logic              addr_hit;

   assign reg_sel = bus_addr[REG_AW-1:0];
   if (ADDR_W > REG_AW) begin : g_hi_addr
      logic [HI_W-1:0] hi_bits;
      assign hi_bits  = bus_addr[ADDR_W-1:REG_AW];
      assign addr_hit = (hi_bits == '0);
   end else begin : g_no_hi_addr
      assign addr_hit = 1'b1;
   end

   logic [N_PINS-1:0] data_q, dir_q, ien_q, edge_q;
   logic [N_PINS-1:0] pin_sync, flag_q, clr_mask;
   logic              wr_hit;

   assign wr_hit = bus_we && addr_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         dir_q  <= '0;
         ien_q  <= '0;
         edge_q <= '0;
      end else if (wr_hit) begin
         unique case (reg_sel)
            ADR_DATA: data_q <= bus_wdata;
            ADR_DIR:  dir_q  <= bus_wdata;
            ADR_IEN:  ien_q  <= bus_wdata;
            ADR_EDGE: edge_q <= bus_wdata;
            default:  ;
         endcase
      end
   end

   assign clr_mask = (wr_hit && reg_sel == ADR_FLAG) ? bus_wdata : '0;

   gpio_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .async_in (pin_in),
      .sync_out (pin_sync)
   );

   gpio_pin_mux #(.WIDTH(N_PINS), .SER_MASK(SER_MASK)) u_mux (
      .gpio_data (data_q),
      .gpio_dir  (dir_q),
      .pwm_en    (pwm_en),
      .pwm_val   (pwm_val),
      .tmr_en    (tmr_en),
      .tmr_val   (tmr_val),
      .ser_en    (ser_en),
      .ser_val   (ser_val),
      .pad_out   (pad_out),
      .pad_oe    (pad_oe)
   );

   gpio_edge_irq #(.WIDTH(N_PINS)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_sync (pin_sync),
      .rise_sel (edge_q),
      .enable   (ien_q),
      .clr_mask (clr_mask),
      .flags    (flag_q),
      .irq      (irq)
   );

   always_comb begin
      bus_rdata = '0;
      if (addr_hit) begin
         unique case (reg_sel)
            ADR_DATA:  bus_rdata = (data_q & dir_q) | (pin_sync & ~dir_q);
            ADR_DIR:   bus_rdata = dir_q;
            ADR_INPUT: bus_rdata = pin_sync;
            ADR_IEN:   bus_rdata = ien_q;
            ADR_EDGE:  bus_rdata = edge_q;
            ADR_FLAG:  bus_rdata = flag_q;
            default:   bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/gpio_mux_port_chk.sv
module gpio_mux_port_chk
   import gpio_mux_pkg::*;
#(
   parameter int unsigned       N_PINS   = 8,
   parameter int unsigned       ADDR_W   = 3,
   parameter logic [N_PINS-1:0] SER_MASK = 8'hC0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic [N_PINS-1:0] pwm_en,
   input logic [N_PINS-1:0] pwm_val,
   input logic [N_PINS-1:0] tmr_en,
   input logic [N_PINS-1:0] tmr_val,
   input logic [N_PINS-1:0] ser_en,
   input logic [N_PINS-1:0] pad_out,
   input logic [N_PINS-1:0] pad_oe,
   input logic [N_PINS-1:0] data_q,
   input logic [N_PINS-1:0] dir_q,
   input logic [N_PINS-1:0] ien_q,
   input logic [N_PINS-1:0] edge_q,
   input logic [N_PINS-1:0] flag_q,
   input logic              irq
);
   logic [N_PINS-1:0] alt_any;
   assign alt_any = pwm_en | tmr_en | (ser_en & SER_MASK);

   // R3
   pwm_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe & pwm_en) == pwm_en) && (((pad_out ^ pwm_val) & pwm_en) == '0));

   // R3
   tmr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((((pad_out ^ tmr_val) | ~pad_oe) & tmr_en & ~pwm_en) == '0));

   // R2
   gpio_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (((pad_oe ^ dir_q) & ~alt_any) == '0));

   // R4
   ser_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (((pad_oe ^ dir_q) & ser_en & ~SER_MASK & ~pwm_en & ~tmr_en) == '0));

   // R7
   ro_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(ADR_INPUT)) |=>
         ($stable(data_q) && $stable(dir_q) && $stable(ien_q) && $stable(edge_q)));

   // R8
   no_flag_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((flag_q & ~$past(flag_q) & ~$past(ien_q)) == '0));

   // R10
   irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ((flag_q & ien_q) != '0));
endmodule

bind gpio_mux_port gpio_mux_port_chk #(
   .N_PINS(N_PINS), .ADDR_W(ADDR_W), .SER_MASK(SER_MASK)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
   .pwm_en(pwm_en), .pwm_val(pwm_val), .tmr_en(tmr_en), .tmr_val(tmr_val),
   .ser_en(ser_en), .pad_out(pad_out), .pad_oe(pad_oe),
   .data_q(data_q), .dir_q(dir_q), .ien_q(ien_q), .edge_q(edge_q),
   .flag_q(flag_q), .irq(irq)
);

// File: tb/gpio_mux_port_test.sv
module gpio_mux_port_test;
   localparam int unsigned N = 8;
   localparam logic [N-1:0] SMASK = 8'hC0;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [N-1:0] bus_wdata = '0;
   logic bus_we = 1'b0;
   logic [N-1:0] bus_rdata;
   logic [N-1:0] pin_in = '0;
   logic [N-1:0] pwm_en = '0, pwm_val = '0, tmr_en = '0, tmr_val = '0;
   logic [N-1:0] ser_en = '0, ser_val = '0;
   logic [N-1:0] pad_out, pad_oe;
   logic irq;

   int n_chk = 0;
   int n_err = 0;
   logic [N-1:0] m_data = '0, m_dir = '0, m_ien = '0, m_edge = '0, m_flag = '0;
   logic [N-1:0] m_pin = '0;

   always #4 clk = ~clk;

   gpio_mux_port uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pwm_en(pwm_en), .pwm_val(pwm_val), .tmr_en(tmr_en), .tmr_val(tmr_val),
      .ser_en(ser_en), .ser_val(ser_val), .pad_out(pad_out), .pad_oe(pad_oe),
      .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [N-1:0] exp_oe();
      logic [N-1:0] r;
      for (int i = 0; i < N; i++) begin
         if (pwm_en[i] || tmr_en[i] || (ser_en[i] && SMASK[i])) r[i] = 1'b1;
         else r[i] = m_dir[i];
      end
      return r;
   endfunction

   function automatic logic [N-1:0] exp_out();
      logic [N-1:0] r;
      for (int i = 0; i < N; i++) begin
         if (pwm_en[i])                   r[i] = pwm_val[i];
         else if (tmr_en[i])              r[i] = tmr_val[i];
         else if (ser_en[i] && SMASK[i])  r[i] = ser_val[i];
         else                             r[i] = m_data[i];
      end
      return r;
   endfunction

   task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_we = 1'b0;
      case (a)
         3'd0: m_data = d;
         3'd1: m_dir = d;
         3'd3: m_ien = d;
         3'd4: m_edge = d;
         3'd5: m_flag = m_flag & ~d;
         default: ;
      endcase
   endtask

   task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic drive_pins(input logic [N-1:0] v);
      logic [N-1:0] ev;
      @(negedge clk);
      pin_in = v;
      repeat (3) @(posedge clk);
      ev = ((v & ~m_pin & m_edge) | (~v & m_pin & ~m_edge)) & m_ien;
      m_flag = m_flag | ev;
      m_pin = v;
   endtask

   task automatic check_all(input string tag);
      logic [N-1:0] d;
      #1;
      chk({tag, " R2/R3/R4 pad_out"}, pad_out, exp_out());
      chk({tag, " R3 R4 pad_oe"}, pad_oe, exp_oe());
      rd(3'd0, d); chk({tag, " R5 data read"}, d, (m_data & m_dir) | (m_pin & ~m_dir));
      rd(3'd2, d); chk({tag, " R6 input read"}, d, m_pin);
      rd(3'd5, d); chk({tag, " R8 flags"}, d, m_flag);
      chk({tag, " R10 irq"}, irq, |(m_flag & m_ien));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [N-1:0] d;
      void'($urandom(32'h5eed_1234));
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      #1;
      chk("R1 pad_oe", pad_oe, '0);
      chk("R1 irq", irq, 1'b0);
      for (int a = 0; a < 6; a++) begin
         if (a == 0 || a == 2) continue;
         rd(3'(a), d); chk("R1 reg reset", d, '0);
      end

      // R2 GPIO drive, R5 mixed-direction read
      drive_pins(8'h5A);
      wr(3'd0, 8'hC3);
      wr(3'd1, 8'h0F);
      check_all("directed-gpio");

      // R7 writes to input and unused addresses ignored
      wr(3'd2, 8'hFF);
      wr(3'd6, 8'hFF);
      wr(3'd7, 8'hFF);
      rd(3'd1, d); chk("R7 dir unchanged", d, 8'h0F);
      rd(3'd0, d); chk("R7 data unchanged", d, (8'hC3 & 8'h0F) | (8'h5A & 8'hF0));
      rd(3'd6, d); chk("R7 unused reads 0", d, '0);
      rd(3'd2, d); chk("R6 input after write", d, 8'h5A);

      // R4 serial only on masked pins; R3 priority
      @(negedge clk);
      ser_en = 8'hFF; ser_val = 8'hAA; tmr_en = 8'h30; tmr_val = 8'h10; pwm_en = 8'h84; pwm_val = 8'h04;
      check_all("directed-prio");
      @(negedge clk);
      pwm_en = '0; tmr_en = '0; ser_en = '0;

      // R8 edge without enable does not flag; with enable, in output mode
      wr(3'd4, 8'h0F);
      drive_pins(8'hA5);
      check_all("R8 edge-disabled");
      wr(3'd3, 8'hFF);
      drive_pins(8'h5A);
      check_all("R8 edge-enabled");

      // R9 edge beats same-cycle clear
      wr(3'd5, 8'hFF);
      wr(3'd4, 8'h01);
      wr(3'd3, 8'h01);
      @(negedge clk) pin_in = 8'h5B;
      @(posedge clk); @(negedge clk); @(posedge clk);
      @(negedge clk); bus_addr = 3'd5; bus_wdata = 8'h01; bus_we = 1'b1;
      @(posedge clk); @(negedge clk); bus_we = 1'b0;
      m_pin = 8'h5B; m_flag = 8'h01;
      rd(3'd5, d); chk("R9 set wins over clear", d, 8'h01);
      chk("R10 irq on", irq, 1'b1);
      wr(3'd5, 8'h00);
      rd(3'd5, d); chk("R9 write 0 keeps", d, 8'h01);
      wr(3'd3, 8'h00);
      #1 chk("R10 irq off with enable cleared", irq, 1'b0);
      wr(3'd5, 8'h01);
      rd(3'd5, d); chk("R9 w1c", d, 8'h00);

      // random phase
      for (int it = 0; it < 300; it++) begin
         int unsigned k = $urandom_range(0, 3);
         case (k)
            0: wr(3'($urandom_range(0, 7)), N'($urandom));
            1: drive_pins(N'($urandom));
            2: begin
               @(negedge clk);
               pwm_en = N'($urandom) & N'($urandom); pwm_val = N'($urandom);
               tmr_en = N'($urandom) & N'($urandom); tmr_val = N'($urandom);
               ser_en = N'($urandom); ser_val = N'($urandom);
            end
            default: wr(3'd5, N'($urandom));
         endcase
         check_all("random");
      end

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule